// File: doc/BRIEF.md
# Memory-Mapped Free-Running Sync Counter

The block is a read-only peripheral. After reset it counts a slow reference tick and lets software read the count over a small register bus. The tick comes in as a one-cycle enable that is synchronous to the system clock and arrives at 32768 pulses per second. The count starts at zero on reset and wraps modulo 2^CNT_W. Narrower counters are zero-extended to 32 bits on reads.

Bus accesses give their response one cycle after the strobe. A 32-bit read returns the count in a single access. Software that reads 16 bits at a time first reads the low half. That read captures the matching upper half into a halfword latch. A later read at a halfword offset with address bit 1 set returns the latch, so both halves come from one snapshot. The block also holds a constant revision register.

Every write, and every access of an unsupported width or address, gets a one-cycle error pulse and zero data. None of them changes any state.

Top module: `sync_cnt_top`

## Requirements
- R1: While reset is asserted and afterwards, the count and the halfword latch are zero, and `rdata_o`/`err_o` are zero. A high-half read straight after reset returns 0.
- R2: The count increases by one at each clock edge where `tick_i` is 1. It wraps from 2^CNT_W-1 to 0 and holds when `tick_i` is 0.
- R3: A word read (`size_i`=2'b10) at byte address 0x00 returns 0x00000021 one cycle later, with `err_o` low.
- R4: A word read at byte address 0x10 returns the count as it stood before the clock edge that samples the read, with `err_o` low.
- R5: A halfword read (`size_i`=2'b01) with address bit 1 clear decodes the address like a word read. It returns the low 16 bits and loads the latch with the upper 16 bits, or with zero if the address misses. A tick in the same cycle does not change the captured snapshot.
- R6: A halfword read with address bit 1 set returns the latch in bits 15:0 with `err_o` low, at any address. It leaves the latch unchanged.
- R7: A byte read (`size_i`=2'b00) or a read with the reserved size 2'b11 returns 0 with `err_o` high.
- R8: A word read or low-half read at any address other than 0x00 or 0x10 returns 0 with `err_o` high.
- R9: Any write (`wr_i`=1, which takes priority over `rd_i`) returns 0 with `err_o` high. It leaves the count and the latch untouched.
- R10: In a cycle that follows no access, `rdata_o` is 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle reference tick enable |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe (always rejected) |
| addr_i | input | ADDR_W | Byte address within the block |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| rdata_o | output | 32 | Read data, valid one cycle after the strobe |
| err_o | output | 1 | One-cycle error pulse aligned with read data |

## Verification
The bench builds the block with CNT_W=17 and the default 8-bit address. With 17 bits, the count passes 0xFFFF within a few tens of thousands of tick cycles. The upper half then becomes non-zero, so a split read that mixes halves from two different snapshots would show up. Within the run the count also reaches the wrap from 0x1FFFF back to zero, with halfword reads placed on ticking cycles across that boundary.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] REV_VALUE = 32'h0000_0021;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              err;
  } rsp_t;
endpackage

// File: rtl/sync_cnt_counter.sv
module sync_cnt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/sync_cnt_decode.sv
module sync_cnt_decode
  import sync_cnt_pkg::*;
#(
  parameter int unsigned       CNT_W    = 32,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REV_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] word_o,
  output logic              hit_o
);
  logic [DATA_W-1:0] cnt_ext;

  generate
    if (CNT_W < DATA_W) begin : g_ext
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, cnt_i};
    end else begin : g_full
      assign cnt_ext = cnt_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    word_o = '0;
    hit_o  = 1'b0;
    if (addr_i == REV_ADDR) begin
      word_o = REV_VALUE;
      hit_o  = 1'b1;
    end else if (addr_i == CNT_ADDR) begin
      word_o = cnt_ext;
      hit_o  = 1'b1;
    end
  end
endmodule

// File: rtl/sync_cnt_hlatch.sv
module sync_cnt_hlatch
  import sync_cnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [HALF_W-1:0] d_i,
  output logic [HALF_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/sync_cnt_top.sv
module sync_cnt_top
  import sync_cnt_pkg::*;
#(
  parameter int unsigned       CNT_W    = 32,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REV_ADDR = 'h00,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] word;
  logic              hit;
  logic              hl_ld;
  logic [HALF_W-1:0] hl_d;
  logic [HALF_W-1:0] hl_q;
  rsp_t              rsp_d;
  rsp_t              rsp_q;
  acc_size_e         size;

  assign size = acc_size_e'(size_i);

  sync_cnt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .cnt_o (cnt)
  );

  sync_cnt_decode #(
    .CNT_W   (CNT_W),
    .ADDR_W  (ADDR_W),
    .REV_ADDR(REV_ADDR),
    .CNT_ADDR(CNT_ADDR)
  ) u_decode (
    .addr_i(addr_i),
    .cnt_i (cnt),
    .word_o(word),
    .hit_o (hit)
  );

  sync_cnt_hlatch u_hlatch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (hl_ld),
    .d_i   (hl_d),
    .q_o   (hl_q)
  );

  // Writes win over reads; decode is sampled on the same edge as the counter.
  always_comb begin
    rsp_d = '0;
    hl_ld = 1'b0;
    hl_d  = '0;
    if (wr_i) begin
      rsp_d.err = 1'b1;
    end else if (rd_i) begin
      unique case (size)
        SZ_WORD: begin
          rsp_d.data = hit ? word : '0;
          rsp_d.err  = !hit;
        end
        SZ_HALF: begin
          if (addr_i[1]) begin
            rsp_d.data = {{HALF_W{1'b0}}, hl_q};
          end else begin
            rsp_d.data = {{HALF_W{1'b0}}, hit ? word[HALF_W-1:0] : {HALF_W{1'b0}}};
            rsp_d.err  = !hit;
            hl_ld      = 1'b1;
            hl_d       = hit ? word[DATA_W-1:HALF_W] : '0;
          end
        end
        default: rsp_d.err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_q <= '0;
    else         rsp_q <= rsp_d;
  end

  assign rdata_o = rsp_q.data;
  assign err_o   = rsp_q.err;

  assert_rev_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 2'b10 && addr_i == REV_ADDR)
      |=> (rdata_o == REV_VALUE && !err_o));
  assert_coherent_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 2'b01 && addr_i == CNT_ADDR) ##1
    (rd_i && !wr_i && size_i == 2'b01 && addr_i[1])
      |=> (rdata_o == {{HALF_W{1'b0}}, $past(word[DATA_W-1:HALF_W], 2)} && !err_o));
  assert_high_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == 2'b01 && addr_i[1])
      |=> (rdata_o == {{HALF_W{1'b0}}, $past(hl_q)} && !err_o && $stable(hl_q)));
  assert_bad_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && (size_i == 2'b00 || size_i == 2'b11))
      |=> (err_o && rdata_o == '0));
  assert_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (err_o && rdata_o == '0 && $stable(hl_q)));
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i || wr_i) |=> (!err_o && rdata_o == '0));
endmodule

// File: tb/sync_cnt_top_bench.sv
module sync_cnt_top_bench;
  localparam int CNT_W = 17;
  localparam int CNT_MOD = 1 << CNT_W;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] rdata_o;
  logic        err_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    m_cnt = 0;
  int    m_latch = 0;
  bit    exp_valid = 1'b0;
  int    exp_d = 0;
  bit    exp_e = 1'b0;
  string exp_tag = "";
  bit    done = 1'b0;

  always #5 clk_i = ~clk_i;

  sync_cnt_top #(.CNT_W(CNT_W)) u_sync_cnt_top (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rd_i   (rd_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .size_i (size_i),
    .rdata_o(rdata_o),
    .err_o  (err_o)
  );

  task automatic compare();
    if (exp_valid) begin
      n_cmp++;
      if (rdata_o !== 32'(exp_d) || err_o !== exp_e) begin
        n_bad++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 exp_tag, rdata_o, err_o, 32'(exp_d), exp_e);
      end
    end
  endtask

  task automatic model_word(input int a, output int d, output bit e, output string t);
    if (a == 'h00) begin d = 'h21; e = 0; t = "R3"; end
    else if (a == 'h10) begin d = m_cnt; e = 0; t = "R4"; end
    else begin d = 0; e = 1; t = "R8"; end
  endtask

  // Compare the previous cycle's response, then drive and predict the next one.
  task automatic cyc(input bit rd, input bit wr, input int a, input int sz,
                     input bit tk, input string tag);
    int d; bit e; string t;
    @(negedge clk_i);
    compare();
    rd_i = rd; wr_i = wr; addr_i = 8'(a); size_i = 2'(sz); tick_i = tk;
    d = 0; e = 0; t = "R10";
    if (wr) begin e = 1; t = "R9"; end
    else if (rd) begin
      if (sz == 2) model_word(a, d, e, t);
      else if (sz == 1) begin
        if ((a & 2) != 0) begin d = m_latch; e = 0; t = "R6"; end
        else begin
          model_word(a, d, e, t);
          m_latch = e ? 0 : (d >>> 16) & 'hFFFF;
          d = d & 'hFFFF;
          t = (t == "R8") ? "R8" : "R5";
        end
      end else begin e = 1; t = "R7"; end
    end
    if (tk) m_cnt = (m_cnt + 1) % CNT_MOD;
    exp_d = d; exp_e = e; exp_tag = (tag != "") ? tag : t; exp_valid = 1'b1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
    end
  end

  initial begin
    // R1: outputs quiet during reset
    repeat (3) begin
      @(negedge clk_i);
      n_cmp++;
      if (rdata_o !== '0 || err_o !== 1'b0) begin
        n_bad++;
        $display("FAIL R1: rdata=%h err=%b expected rdata=0 err=0", rdata_o, err_o);
      end
    end
    rst_ni = 1'b1;
    cyc(1, 0, 'h02, 1, 0, "R1");   // latch reset to zero
    cyc(1, 0, 'h10, 2, 0, "R1");   // count reset to zero
    cyc(0, 0, 0, 0, 0, "");
    // R2 ticks with idle bus, then R4 read
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 1, "R2");
    cyc(1, 0, 'h10, 2, 1, "R4");
    cyc(1, 0, 'h10, 2, 0, "R2");
    cyc(1, 0, 'h00, 2, 1, "R3");
    cyc(1, 0, 'h00, 1, 0, "R5");   // revision low half, latch <- 0
    cyc(1, 0, 'h02, 1, 0, "R6");
    cyc(1, 0, 'h10, 1, 1, "R5");   // tick in same cycle
    cyc(1, 0, 'h12, 1, 0, "R6");
    cyc(1, 0, 'h10, 0, 0, "R7");
    cyc(1, 0, 'h10, 3, 0, "R7");
    cyc(1, 0, 'h04, 2, 0, "R8");
    cyc(1, 0, 'h08, 1, 0, "R8");
    cyc(0, 1, 'h10, 2, 1, "R9");
    cyc(1, 1, 'h00, 2, 0, "R9");   // write wins
    cyc(1, 0, 'h10, 2, 0, "R9");   // count unaffected by writes
    cyc(0, 0, 0, 0, 0, "R10");
    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int sel; int a;
      sel = $urandom_range(0, 4);
      a = (sel == 0) ? 'h00 : (sel == 1) ? 'h10 : (sel == 2) ? 'h12 :
          (sel == 3) ? 'h02 : int'($urandom_range(0, 255));
      cyc($urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0, a,
          $urandom_range(0, 3), $urandom_range(0, 2) == 0, "");
    end
    // Continuous ticks past 0xFFFF and through the wrap, with split reads
    for (int i = 0; i < 131300; i++) begin
      if (i % 97 == 0)      cyc(1, 0, 'h10, 1, 1, "");
      else if (i % 97 == 1) cyc(1, 0, 'h12, 1, 1, "");
      else if (i % 97 == 2) cyc(1, 0, 'h10, 2, 1, "");
      else                  cyc(0, 0, 0, 0, 1, "R2");
    end
    cyc(0, 0, 0, 0, 0, "");
    @(negedge clk_i);
    compare();
    done = 1'b1;
    summary();
  end
endmodule